// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Unit

This block is the processor-facing side of an interrupt controller for one CPU. An arbiter elsewhere finds the best pending interrupt and gives its ID and priority to this block. Software reads an acknowledge register to take that interrupt. Later it writes the same ID to an end-of-interrupt register to finish it. The block tracks which interrupt is running and at what priority. Through the pending-clear and pending-set pulses it tells the arbiter what must change in the pending state.

Interrupts can nest. A higher-priority interrupt can be acknowledged while another is running. The block then records the interrupt it preempted as the predecessor of the new one, in a table with one entry per interrupt ID. These links form a chain from the running interrupt back to idle. Software may complete an interrupt that is not at the head of the chain. In that case a small walker follows the chain one link per cycle and splices that entry out. It holds off further bus accesses while it works.

The block also holds a per-CPU enable bit and a priority mask. It reports the running priority and the highest pending ID as seen through that mask. It drives an interrupt request line toward the CPU.

Top module: `aci_cpu_if`

## Requirements
- R1: After reset the enable bit is 0, the mask is 0xF0, the running priority reads 0x100, the highest-pending register reads 1023, `irq_out` is low and `busy` is low.
- R2: Registers are decoded from `req_addr[4:2]`: 0x00 enable (bit 0), 0x04 mask, 0x08 binary point (reads 0, writes have no effect), 0x0C acknowledge, 0x10 end of interrupt, 0x14 running priority, 0x18 highest pending. A read accepted in one cycle gives `rsp_valid` and `rsp_rdata` after the next clock edge. A mask write keeps only bits [7:0].
- R3: The highest-pending register returns `hp_id` when the enable bit is set and `hp_prio` is at or below the mask; otherwise it returns 1023. `irq_out` is high when that value is not 1023 and `hp_prio` is strictly below the running priority.
- R4: An acknowledge read returns 1023 and changes nothing if the highest-pending value is 1023 or `hp_prio` is not strictly below the running priority. No pending-clear pulse is issued.
- R5: A successful acknowledge returns the ID and makes it running with `hp_prio` as the running priority. It issues a one-cycle pending-clear pulse for that ID, with `pend_clr_all` equal to the ID's bit in `cfg_one_of_n`.
- R6: An end-of-interrupt write while the running ID is 1023 is ignored. The running state does not change and no pending-set pulse is issued.
- R7: On an accepted end-of-interrupt for ID n, a one-cycle pending-set pulse for n is issued when all of these hold: `cfg_edge[n]` is 0, `cfg_enable[n]` is 1, `cfg_level[n]` is 1 and `cfg_target[n]` is 1.
- R8: Completing the running interrupt restores its predecessor's ID and priority. If there is no predecessor, the running ID becomes 1023 and the running priority becomes 0x100.
- R9: Completing an interrupt that is not running leaves the running interrupt unchanged. It raises `busy` while the chain is walked and removes that interrupt from the chain. Later completions then skip it.
- R10: While `busy` is high, requests are ignored. They produce no response and write no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| busy | output | 1 | Chain walk in progress; requests ignored |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| hp_id | input | 10 | Best pending ID from the arbiter (1023 = none) |
| hp_prio | input | 8 | Priority of `hp_id` |
| cfg_level | input | NUM_IRQ | Input line level per interrupt |
| cfg_enable | input | NUM_IRQ | Interrupt enable per interrupt |
| cfg_edge | input | NUM_IRQ | 1 = edge triggered |
| cfg_target | input | NUM_IRQ | Interrupt targets this CPU |
| cfg_one_of_n | input | NUM_IRQ | 1 = acknowledge clears pending on all CPUs |
| irq_out | output | 1 | Interrupt request to the CPU |
| pend_clr_valid | output | 1 | Pending-clear pulse |
| pend_clr_id | output | 10 | ID to clear |
| pend_clr_all | output | 1 | Clear for all CPUs |
| pend_set_valid | output | 1 | Pending-set pulse |
| pend_set_id | output | 10 | ID to set pending again |

## Verification
Read data and both pulses are due exactly one clock edge after the edge that accepts the request. The bench drives each request on a falling edge for one cycle and samples on the next falling edge. `irq_out` and `busy` are sampled on that same falling edge, once the registered state has settled. An out-of-order completion keeps `busy` high for one cycle per link walked. The bench checks `busy` right after the accepting edge, probes two requests during the walk, and then waits at falling edges until `busy` drops. Only then does it read the running priority.

// File: rtl/aci_pkg.sv
package aci_pkg;
  localparam int unsigned ID_W   = 10;
  localparam int unsigned PRIO_W = 8;

  localparam logic [ID_W-1:0]  ID_NONE   = 10'h3FF;
  localparam logic [PRIO_W:0]  PRIO_IDLE = 9'h100;

  // one predecessor link: the interrupt that was running before, and its priority
  typedef struct packed {
    logic [ID_W-1:0] id;
    logic [PRIO_W:0] prio;
  } link_t;

  localparam link_t LINK_EMPTY = '{id: ID_NONE, prio: PRIO_IDLE};

  // word index of each register, req_addr[4:2]
  typedef enum logic [2:0] {
    OFS_CTRL  = 3'd0,
    OFS_MASK  = 3'd1,
    OFS_BPT   = 3'd2,
    OFS_ACK   = 3'd3,
    OFS_EOI   = 3'd4,
    OFS_RPRI  = 3'd5,
    OFS_HPEND = 3'd6
  } reg_ofs_e;
endpackage

// File: rtl/aci_link_table.sv
module aci_link_table import aci_pkg::*; #(
  parameter int unsigned NUM_IRQ  = 64,
  parameter int unsigned RD_PORTS = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ID_W-1:0] rd_idx [RD_PORTS],
  output link_t           rd_data [RD_PORTS],
  input  logic            wr_en,
  input  logic [ID_W-1:0] wr_idx,
  input  link_t           wr_data
);
  localparam int unsigned     IDX_W      = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam logic [ID_W-1:0] NUM_IRQ_ID = ID_W'(NUM_IRQ);

  link_t mem_q [NUM_IRQ];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < NUM_IRQ; e++) mem_q[e] <= LINK_EMPTY;
    end else if (wr_en && (wr_idx < NUM_IRQ_ID)) begin
      mem_q[wr_idx[IDX_W-1:0]] <= wr_data;
    end
  end

  // out-of-range IDs (including 1023) read as an empty link
  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    always_comb begin
      if (rd_idx[p] < NUM_IRQ_ID) rd_data[p] = mem_q[rd_idx[p][IDX_W-1:0]];
      else                        rd_data[p] = LINK_EMPTY;
    end
  end
endmodule

// File: rtl/aci_chain_walker.sv
module aci_chain_walker import aci_pkg::*; #(
  parameter int unsigned NUM_IRQ = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [ID_W-1:0] start_cur,
  input  logic [ID_W-1:0] start_tgt,
  input  link_t           lk_cur,
  input  link_t           lk_tgt,
  output logic [ID_W-1:0] cur_idx,
  output logic [ID_W-1:0] tgt_idx,
  output logic            busy,
  output logic            wr_en,
  output logic [ID_W-1:0] wr_idx,
  output link_t           wr_data
);
  localparam int unsigned    CNT_W     = $clog2(NUM_IRQ + 1);
  localparam logic [CNT_W-1:0] STEP_LAST = CNT_W'(NUM_IRQ);

  typedef enum logic {W_IDLE, W_WALK} wstate_e;

  wstate_e          st_q, st_d;
  logic [ID_W-1:0]  cur_q, cur_d, tgt_q, tgt_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ld_en;

  always_comb begin
    st_d  = st_q;
    cur_d = cur_q;
    tgt_d = tgt_q;
    cnt_d = cnt_q;
    wr_en = 1'b0;
    ld_en = 1'b0;
    unique case (st_q)
      W_IDLE: begin
        if (start) begin
          st_d  = W_WALK;
          cur_d = start_cur;
          tgt_d = start_tgt;
          cnt_d = '0;
          ld_en = 1'b1;
        end
      end
      W_WALK: begin
        if (lk_cur.id == ID_NONE || cnt_q == STEP_LAST) begin
          st_d = W_IDLE;
        end else if (lk_cur.id == tgt_q) begin
          wr_en = 1'b1;
          st_d  = W_IDLE;
        end else begin
          cur_d = lk_cur.id;
          cnt_d = cnt_q + 1'b1;
          ld_en = 1'b1;
        end
      end
      default: st_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= W_IDLE;
      cur_q <= ID_NONE;
      tgt_q <= ID_NONE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (ld_en) begin
        cur_q <= cur_d;
        tgt_q <= tgt_d;
        cnt_q <= cnt_d;
      end
    end
  end

  assign busy    = (st_q == W_WALK);
  assign cur_idx = cur_q;
  assign tgt_idx = tgt_q;
  assign wr_idx  = cur_q;
  assign wr_data = lk_tgt;

  // R9: a new walk is only launched from idle
  p_start_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> st_q == W_IDLE);
  // R9: a splice write ends the walk
  p_splice_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !busy);
endmodule

// File: rtl/aci_cpu_if.sv
module aci_cpu_if import aci_pkg::*; #(
  parameter int unsigned      NUM_IRQ    = 64,
  parameter logic [PRIO_W-1:0] MASK_RESET = 8'hF0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [4:0]         req_addr,
  input  logic [31:0]        req_wdata,
  output logic               busy,
  output logic               rsp_valid,
  output logic [31:0]        rsp_rdata,
  input  logic [ID_W-1:0]    hp_id,
  input  logic [PRIO_W-1:0]  hp_prio,
  input  logic [NUM_IRQ-1:0] cfg_level,
  input  logic [NUM_IRQ-1:0] cfg_enable,
  input  logic [NUM_IRQ-1:0] cfg_edge,
  input  logic [NUM_IRQ-1:0] cfg_target,
  input  logic [NUM_IRQ-1:0] cfg_one_of_n,
  output logic               irq_out,
  output logic               pend_clr_valid,
  output logic [ID_W-1:0]    pend_clr_id,
  output logic               pend_clr_all,
  output logic               pend_set_valid,
  output logic [ID_W-1:0]    pend_set_id
);
  localparam int unsigned     IDX_W      = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam logic [ID_W-1:0] NUM_IRQ_ID = ID_W'(NUM_IRQ);

  // state
  logic              en_q, en_d, ctrl_we;
  logic [PRIO_W-1:0] mask_q, mask_d;
  logic              mask_we;
  logic [ID_W-1:0]   run_id_q, run_id_d;
  logic [PRIO_W:0]   run_prio_q, run_prio_d;
  logic              run_we;
  logic              rsp_valid_q;
  logic [31:0]       rsp_rdata_q, rsp_rdata_d;
  logic              pclr_v_q, pclr_all_q, pclr_all_d;
  logic [ID_W-1:0]   pclr_id_q;
  logic              pset_v_q;
  logic [ID_W-1:0]   pset_id_q;

  // decode
  reg_ofs_e          ofs;
  logic              accept, rd_go;
  logic [ID_W-1:0]   eff_id, eoi_id;
  logic              preempt, ack_go, eoi_go, eoi_top, walk_go, refire;
  logic [IDX_W-1:0]  eoi_idx, ack_idx;
  logic              eoi_in, ack_in;

  // link table ports: 0 = running entry, 1 = walk cursor, 2 = walk target
  logic [ID_W-1:0]   lk_idx [3];
  link_t             lk_dat [3];
  logic              lk_we;
  logic [ID_W-1:0]   lk_widx;
  link_t             lk_wdat;

  logic              wk_busy, wk_we;
  logic [ID_W-1:0]   wk_cur, wk_tgt, wk_widx;
  link_t             wk_wdat;

  logic              unused_bits;
  assign unused_bits = ^{req_addr[1:0], req_wdata[31:ID_W]};

  assign ofs     = reg_ofs_e'(req_addr[4:2]);
  assign accept  = req_valid && !wk_busy;
  assign rd_go   = accept && !req_write;

  assign eff_id  = (en_q && hp_prio <= mask_q) ? hp_id : ID_NONE;
  assign preempt = (eff_id != ID_NONE) && ({1'b0, hp_prio} < run_prio_q);

  assign ack_go  = rd_go && (ofs == OFS_ACK) && preempt;
  assign ack_in  = eff_id < NUM_IRQ_ID;
  assign ack_idx = eff_id[IDX_W-1:0];

  assign eoi_id  = req_wdata[ID_W-1:0];
  assign eoi_go  = accept && req_write && (ofs == OFS_EOI) && (run_id_q != ID_NONE);
  assign eoi_top = eoi_go && (eoi_id == run_id_q);
  assign walk_go = eoi_go && (eoi_id != run_id_q);
  assign eoi_in  = eoi_id < NUM_IRQ_ID;
  assign eoi_idx = eoi_id[IDX_W-1:0];
  assign refire  = eoi_go && eoi_in && !cfg_edge[eoi_idx] && cfg_enable[eoi_idx]
                   && cfg_level[eoi_idx] && cfg_target[eoi_idx];

  // next state
  always_comb begin
    ctrl_we    = accept && req_write && (ofs == OFS_CTRL);
    mask_we    = accept && req_write && (ofs == OFS_MASK);
    en_d       = req_wdata[0];
    mask_d     = req_wdata[PRIO_W-1:0];
    run_we     = ack_go || eoi_top;
    run_id_d   = ack_go ? eff_id : lk_dat[0].id;
    run_prio_d = ack_go ? {1'b0, hp_prio} : lk_dat[0].prio;
    pclr_all_d = ack_in && cfg_one_of_n[ack_idx];
    unique case (ofs)
      OFS_CTRL:  rsp_rdata_d = {31'd0, en_q};
      OFS_MASK:  rsp_rdata_d = {{(32-PRIO_W){1'b0}}, mask_q};
      OFS_ACK:   rsp_rdata_d = {{(32-ID_W){1'b0}}, preempt ? eff_id : ID_NONE};
      OFS_RPRI:  rsp_rdata_d = {{(31-PRIO_W){1'b0}}, run_prio_q};
      OFS_HPEND: rsp_rdata_d = {{(32-ID_W){1'b0}}, eff_id};
      default:   rsp_rdata_d = 32'd0;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q        <= 1'b0;
      mask_q      <= MASK_RESET;
      run_id_q    <= ID_NONE;
      run_prio_q  <= PRIO_IDLE;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
      pclr_v_q    <= 1'b0;
      pclr_id_q   <= ID_NONE;
      pclr_all_q  <= 1'b0;
      pset_v_q    <= 1'b0;
      pset_id_q   <= ID_NONE;
    end else begin
      if (ctrl_we) en_q <= en_d;
      if (mask_we) mask_q <= mask_d;
      if (run_we) begin
        run_id_q   <= run_id_d;
        run_prio_q <= run_prio_d;
      end
      rsp_valid_q <= rd_go;
      if (rd_go) rsp_rdata_q <= rsp_rdata_d;
      pclr_v_q <= ack_go;
      if (ack_go) begin
        pclr_id_q  <= eff_id;
        pclr_all_q <= pclr_all_d;
      end
      pset_v_q <= refire;
      if (refire) pset_id_q <= eoi_id;
    end
  end

  // link storage and chain walker
  assign lk_idx[0] = run_id_q;
  assign lk_idx[1] = wk_cur;
  assign lk_idx[2] = wk_tgt;
  assign lk_we     = ack_go || wk_we;
  assign lk_widx   = ack_go ? eff_id : wk_widx;
  assign lk_wdat   = ack_go ? link_t'{id: run_id_q, prio: run_prio_q} : wk_wdat;

  aci_link_table #(.NUM_IRQ(NUM_IRQ), .RD_PORTS(3)) u_links (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (lk_idx),
    .rd_data (lk_dat),
    .wr_en   (lk_we),
    .wr_idx  (lk_widx),
    .wr_data (lk_wdat)
  );

  aci_chain_walker #(.NUM_IRQ(NUM_IRQ)) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (walk_go),
    .start_cur (run_id_q),
    .start_tgt (eoi_id),
    .lk_cur    (lk_dat[1]),
    .lk_tgt    (lk_dat[2]),
    .cur_idx   (wk_cur),
    .tgt_idx   (wk_tgt),
    .busy      (wk_busy),
    .wr_en     (wk_we),
    .wr_idx    (wk_widx),
    .wr_data   (wk_wdat)
  );

  assign busy           = wk_busy;
  assign rsp_valid      = rsp_valid_q;
  assign rsp_rdata      = rsp_rdata_q;
  assign irq_out        = preempt;
  assign pend_clr_valid = pclr_v_q;
  assign pend_clr_id    = pclr_id_q;
  assign pend_clr_all   = pclr_all_q;
  assign pend_set_valid = pset_v_q;
  assign pend_set_id    = pset_id_q;

  // R8: idle running ID and idle running priority go together
  p_idle_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_id_q == ID_NONE) == (run_prio_q == PRIO_IDLE));
  // R5: a successful acknowledge always raises the running priority level
  p_ack_raises_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_go |=> run_prio_q < $past(run_prio_q));
  // R6: completion with nothing running leaves the state alone
  p_eoi_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write && ofs == OFS_EOI && run_id_q == ID_NONE)
      |=> ($stable(run_id_q) && !pend_set_valid));
  // R9: the running interrupt is untouched during a walk
  p_walk_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wk_busy |=> $stable(run_id_q));
  // R10: no response to a request made while busy
  p_busy_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && wk_busy) |=> !rsp_valid);
  // R5, R7: acknowledge and completion pulses never coincide
  p_pulse_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend_clr_valid && pend_set_valid));
endmodule

// File: tb/sim_aci_cpu_if.sv
`timescale 1ns/1ps
module sim_aci_cpu_if;
  localparam int NIRQ = 64;
  localparam logic [4:0] A_CTRL = 5'h00, A_MASK = 5'h04, A_BPT = 5'h08, A_ACK = 5'h0C,
                         A_EOI = 5'h10, A_RPRI = 5'h14, A_HPEND = 5'h18;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write;
  logic [4:0] req_addr;
  logic [31:0] req_wdata;
  logic busy, rsp_valid;
  logic [31:0] rsp_rdata;
  logic [9:0] hp_id;
  logic [7:0] hp_prio;
  logic [NIRQ-1:0] cfg_level, cfg_enable, cfg_edge, cfg_target, cfg_one_of_n;
  logic irq_out, pend_clr_valid, pend_clr_all, pend_set_valid;
  logic [9:0] pend_clr_id, pend_set_id;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int stk_id [64];
  int stk_pr [64];
  int depth = 0;
  int mask_m = 255;

  always #10 clk = ~clk;

  aci_cpu_if #(.NUM_IRQ(NIRQ)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .hp_id(hp_id), .hp_prio(hp_prio), .cfg_level(cfg_level),
    .cfg_enable(cfg_enable), .cfg_edge(cfg_edge), .cfg_target(cfg_target),
    .cfg_one_of_n(cfg_one_of_n), .irq_out(irq_out), .pend_clr_valid(pend_clr_valid),
    .pend_clr_id(pend_clr_id), .pend_clr_all(pend_clr_all),
    .pend_set_valid(pend_set_valid), .pend_set_id(pend_set_id));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [4:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  function automatic int top_pr();
    return (depth > 0) ? stk_pr[depth-1] : 256;
  endfunction

  function automatic bit in_stack(input int id);
    for (int k = 0; k < depth; k++) if (stk_id[k] == id) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit refire_exp(input int id);
    if (depth == 0 || id >= NIRQ) return 1'b0;
    return !cfg_edge[id] && cfg_enable[id] && cfg_level[id] && cfg_target[id];
  endfunction

  task automatic model_eoi(input int id);
    if (depth == 0) return;
    if (stk_id[depth-1] == id) begin
      depth--;
      return;
    end
    for (int k = depth - 2; k >= 0; k--) begin
      if (stk_id[k] == id) begin
        for (int j = k; j < depth - 1; j++) begin
          stk_id[j] = stk_id[j+1];
          stk_pr[j] = stk_pr[j+1];
        end
        depth--;
        return;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    hp_id = 10'd5; hp_prio = 8'h10;
    cfg_level = '0; cfg_enable = '0; cfg_edge = '0; cfg_target = '0; cfg_one_of_n = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy", {31'd0, busy}, 0);
    chk("R1 irq_out", {31'd0, irq_out}, 0);
    bus(0, A_CTRL, 0);  chk("R1 ctrl", rsp_rdata, 0);
    chk("R2 rsp_valid", {31'd0, rsp_valid}, 1);
    bus(0, A_MASK, 0);  chk("R1 mask", rsp_rdata, 32'hF0);
    bus(0, A_RPRI, 0);  chk("R1 rpri", rsp_rdata, 32'h100);
    bus(0, A_HPEND, 0); chk("R1 hpend", rsp_rdata, 1023);

    // R2 register behaviour
    bus(1, A_MASK, 32'h1AB); bus(0, A_MASK, 0); chk("R2 mask low bits", rsp_rdata, 32'hAB);
    bus(1, A_BPT, 32'hFF);   bus(0, A_BPT, 0);  chk("R2 bpt reads zero", rsp_rdata, 0);
    bus(1, A_CTRL, 32'h3);   bus(0, A_CTRL, 0); chk("R2 ctrl", rsp_rdata, 1);
    @(negedge clk);
    chk("R2 rsp_valid pulse", {31'd0, rsp_valid}, 0);

    // R3 masking and request line
    bus(1, A_MASK, 32'h80);
    hp_id = 10'd5; hp_prio = 8'h80; #1;
    chk("R3 irq at mask", {31'd0, irq_out}, 1);
    bus(0, A_HPEND, 0); chk("R3 hpend at mask", rsp_rdata, 5);
    hp_prio = 8'h81; #1;
    chk("R3 irq above mask", {31'd0, irq_out}, 0);
    bus(0, A_HPEND, 0); chk("R3 hpend above mask", rsp_rdata, 1023);
    hp_prio = 8'h40;
    bus(1, A_CTRL, 0); bus(0, A_HPEND, 0); chk("R3 hpend disabled", rsp_rdata, 1023);
    bus(1, A_CTRL, 1);

    // R5 acknowledge, R4 refused acknowledge
    cfg_one_of_n = '0; cfg_one_of_n[5] = 1'b1;
    hp_id = 10'd5; hp_prio = 8'h40;
    bus(0, A_ACK, 0);
    chk("R5 ack id", rsp_rdata, 5);
    chk("R5 clr pulse", {31'd0, pend_clr_valid}, 1);
    chk("R5 clr id", {22'd0, pend_clr_id}, 5);
    chk("R5 clr all", {31'd0, pend_clr_all}, 1);
    bus(0, A_RPRI, 0); chk("R5 rpri", rsp_rdata, 32'h40);
    chk("R5 clr one cycle", {31'd0, pend_clr_valid}, 0);
    hp_id = 10'd7; hp_prio = 8'h40; #1;
    chk("R4 irq equal prio", {31'd0, irq_out}, 0);
    bus(0, A_ACK, 0);
    chk("R4 ack equal prio", rsp_rdata, 1023);
    chk("R4 no clr", {31'd0, pend_clr_valid}, 0);
    bus(0, A_RPRI, 0); chk("R4 rpri kept", rsp_rdata, 32'h40);

    hp_prio = 8'h30; bus(0, A_ACK, 0);
    chk("R5 nest ack", rsp_rdata, 7);
    chk("R5 clr this cpu", {31'd0, pend_clr_all}, 0);
    hp_id = 10'd9; hp_prio = 8'h20; bus(0, A_ACK, 0);
    chk("R5 nest ack 2", rsp_rdata, 9);
    hp_id = 10'h3FF;

    // R9 out-of-order completion with R10 stall
    bus(1, A_EOI, 5);
    chk("R9 busy", {31'd0, busy}, 1);
    bus(0, A_CTRL, 0);
    chk("R10 no rsp while busy", {31'd0, rsp_valid}, 0);
    bus(1, A_MASK, 32'h10);
    wait_idle();
    bus(0, A_MASK, 0); chk("R10 mask untouched", rsp_rdata, 32'h80);
    bus(0, A_RPRI, 0); chk("R9 rpri unchanged", rsp_rdata, 32'h20);

    // R8 completion of running interrupt
    bus(1, A_EOI, 9); wait_idle();
    bus(0, A_RPRI, 0); chk("R8 restore", rsp_rdata, 32'h30);
    bus(1, A_EOI, 7); wait_idle();
    bus(0, A_RPRI, 0); chk("R9 skipped removed", rsp_rdata, 32'h100);

    // R6 completion while idle
    cfg_level[5] = 1; cfg_enable[5] = 1; cfg_target[5] = 1; cfg_edge[5] = 0;
    bus(1, A_EOI, 5);
    chk("R6 no set", {31'd0, pend_set_valid}, 0);
    chk("R6 no busy", {31'd0, busy}, 0);
    bus(0, A_RPRI, 0); chk("R6 rpri idle", rsp_rdata, 32'h100);

    // R7 re-pend of level interrupt
    cfg_level[3] = 1; cfg_enable[3] = 1; cfg_target[3] = 1; cfg_edge[3] = 0;
    hp_id = 10'd3; hp_prio = 8'h10; bus(0, A_ACK, 0); hp_id = 10'h3FF;
    bus(1, A_EOI, 3);
    chk("R7 set pulse", {31'd0, pend_set_valid}, 1);
    chk("R7 set id", {22'd0, pend_set_id}, 3);
    cfg_edge[3] = 1;
    hp_id = 10'd3; bus(0, A_ACK, 0); hp_id = 10'h3FF;
    bus(1, A_EOI, 3);
    chk("R7 edge no set", {31'd0, pend_set_valid}, 0);

    // random phase
    bus(1, A_MASK, 32'hFF); mask_m = 255; depth = 0;
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom % 3;
      cfg_level    = {$urandom, $urandom};
      cfg_enable   = {$urandom, $urandom};
      cfg_edge     = {$urandom, $urandom};
      cfg_target   = {$urandom, $urandom};
      cfg_one_of_n = {$urandom, $urandom};
      if (op == 0 && depth < 60) begin
        int id, pr, eff;
        bit ok;
        do id = $urandom % NIRQ; while (in_stack(id));
        pr = $urandom % 256;
        hp_id = 10'(id); hp_prio = 8'(pr);
        eff = (pr <= mask_m) ? id : 1023;
        ok = (eff != 1023) && (pr < top_pr());
        #1 chk("R3 rnd irq_out", {31'd0, irq_out}, {31'd0, ok});
        bus(0, A_ACK, 0);
        chk("R4 R5 rnd ack", rsp_rdata, ok ? id : 1023);
        chk("R5 rnd clr", {31'd0, pend_clr_valid}, {31'd0, ok});
        if (ok) begin
          chk("R5 rnd clr id", {22'd0, pend_clr_id}, id);
          chk("R5 rnd clr all", {31'd0, pend_clr_all}, {31'd0, cfg_one_of_n[id]});
          stk_id[depth] = id; stk_pr[depth] = pr; depth++;
        end
      end else if (op == 1) begin
        int id;
        bit rf;
        if (depth > 0 && ($urandom % 4) != 0) id = stk_id[$urandom % depth];
        else id = $urandom % NIRQ;
        rf = refire_exp(id);
        bus(1, A_EOI, 32'(id));
        chk("R7 rnd set", {31'd0, pend_set_valid}, {31'd0, rf});
        if (rf) chk("R7 rnd set id", {22'd0, pend_set_id}, id);
        wait_idle();
        model_eoi(id);
        bus(0, A_RPRI, 0);
        chk("R8 R9 rnd rpri", rsp_rdata, top_pr());
      end else begin
        int m, id, pr;
        m = $urandom % 256;
        bus(1, A_MASK, 32'(m)); mask_m = m;
        id = $urandom % NIRQ; pr = $urandom % 256;
        hp_id = 10'(id); hp_prio = 8'(pr);
        bus(0, A_HPEND, 0);
        chk("R3 rnd hpend", rsp_rdata, (pr <= m) ? id : 1023);
        if (($urandom % 4) == 0) begin
          bus(1, A_MASK, 32'hFF); mask_m = 255;
        end
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule